// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the combinational integer execute unit of a RISC pipeline. Each cycle it takes a 6-bit operation code and two 32-bit operands and returns a 32-bit result. The first operand always comes from a register. The second operand comes either from a register or from a 13-bit immediate that is sign-extended to 32 bits. The block also returns four condition flags (negative, zero, overflow, carry) and a write enable that tells the flag register to capture them.

The supported operations are:
- add, subtract and add-with-carry;
- the three basic logical operations;
- three logical forms that invert the second operand first;
- left and right logical shifts and the arithmetic right shift.

Every arithmetic and logical operation has a second encoding that also updates the flags. That encoding lies exactly 16 codes above the plain one. Any code outside the assigned set is reported as illegal and produces no visible effect. The surrounding pipeline supplies the current carry flag and registers the outputs. The block holds no state of its own.

Top module: `cc_alu`

## Requirements
- R1: Codes 0, 1, 2, 3 and 4 produce A+B, A&B, A|B, A^B and A-B, modulo 2^32.
- R2: Codes 5, 6 and 7 produce A&~B, A|~B and A^~B.
- R3: Code 8 (and its flag form 24) produces A+B+carry_in. Its overflow and carry flags are computed on the effective addend B+carry_in.
- R4: Codes 16..24 give the same result as code minus 16 and drive flag_we high. Every other code drives flag_we low, and all four flag outputs read 0 while flag_we is low.
- R5: With flag_we high, flag_z is 1 exactly when the result is zero, and flag_n equals result bit 31.
- R6: For the add forms (codes 16 and 24), with a=A[31], b=addend[31] and r=result[31]:
  - flag_v = (a&b&~r)|(~a&~b&r);
  - flag_c = (a&b)|(~r&(a|b)).
- R7: For code 20 (subtract), with the same a, b and r:
  - flag_v = (a&~b&~r)|(~a&b&r);
  - flag_c = (~a&b)|(r&(~a|b)).
- R8: The logical flag forms (codes 17, 18, 19, 21, 22 and 23) always give flag_v=0 and flag_c=0, whatever carry_in is.
- R9: Code 0x25 shifts left logically, 0x26 shifts right logically and 0x27 shifts right arithmetically, filling the vacated bits with copies of bit 31. The shift count is the low 5 bits of the second operand. Shifts never write flags.
- R10: When imm_sel is 1, the second operand is imm_val sign-extended from bit 12, and src_b has no effect on any output.
- R11: Any other code drives illegal_op high, result to 0 and flag_we low. On every assigned code, illegal_op is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Operation select |
| src_a | input | 32 | First operand (register) |
| src_b | input | 32 | Second operand when imm_sel is 0 |
| imm_sel | input | 1 | Selects the immediate as the second operand |
| imm_val | input | 13 | Signed immediate |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |
| flag_we | output | 1 | Flag write enable |
| illegal_op | output | 1 | Unassigned operation code |

## Verification
The hardest case to reach is add-with-carry when carry_in turns an all-ones-minus-one addend into a wrap. The flags then depend on the effective addend and not on src_b. The stimulus table contains an add-with-carry vector whose sum wraps to exactly zero, plus the same operands with carry clear, so that the zero flag and the carry equation are both exercised at that edge. Immediate vectors carry a deliberately different src_b, which shows at the result that src_b was ignored. Register-sourced shift counts with bits above bit 4 set confirm that only the low five bits count.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

  localparam int OP_W = 6;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } shift_e;

  typedef struct packed {
    logic   legal;
    logic   set_cc;
    unit_e  unit;
    logic   is_sub;
    logic   use_cin;
    logic_e lop;
    logic   inv_b;
    shift_e sop;
  } dec_t;

  localparam logic [OP_W-1:0] CC_OFFSET = 6'd16;
  localparam logic [OP_W-1:0] OP_SHL    = 6'h25;
  localparam logic [OP_W-1:0] OP_SHR    = 6'h26;
  localparam logic [OP_W-1:0] OP_SAR    = 6'h27;

  function automatic dec_t decode_op(input logic [OP_W-1:0] op);
    dec_t d;
    logic [OP_W-1:0] base;
    d = '0;
    d.unit = UNIT_ARITH;
    d.lop  = LG_AND;
    d.sop  = SH_LEFT;
    base   = op;
    if (op >= CC_OFFSET && op <= CC_OFFSET + 6'd8) begin
      d.set_cc = 1'b1;
      base     = op - CC_OFFSET;
    end
    if (base <= 6'd8) begin
      d.legal = 1'b1;
      case (base)
        6'd0: d.unit = UNIT_ARITH;
        6'd1: begin d.unit = UNIT_LOGIC; d.lop = LG_AND; end
        6'd2: begin d.unit = UNIT_LOGIC; d.lop = LG_OR;  end
        6'd3: begin d.unit = UNIT_LOGIC; d.lop = LG_XOR; end
        6'd4: begin d.unit = UNIT_ARITH; d.is_sub = 1'b1; end
        6'd5: begin d.unit = UNIT_LOGIC; d.lop = LG_AND; d.inv_b = 1'b1; end
        6'd6: begin d.unit = UNIT_LOGIC; d.lop = LG_OR;  d.inv_b = 1'b1; end
        6'd7: begin d.unit = UNIT_LOGIC; d.lop = LG_XOR; d.inv_b = 1'b1; end
        default: begin d.unit = UNIT_ARITH; d.use_cin = 1'b1; end
      endcase
    end else if (op == OP_SHL || op == OP_SHR || op == OP_SAR) begin
      d.legal  = 1'b1;
      d.set_cc = 1'b0;
      d.unit   = UNIT_SHIFT;
      d.sop    = (op == OP_SHL) ? SH_LEFT : (op == OP_SHR) ? SH_RIGHT : SH_ARITH;
    end else begin
      d.set_cc = 1'b0;
    end
    return d;
  endfunction

endpackage

// File: rtl/cc_alu_opnd.sv
module cc_alu_opnd #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic [DATA_W-1:0] reg_b,
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    opnd_b  = imm_sel ? imm_ext : reg_b;
  end
endmodule

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_sub,
  input  logic              use_cin,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              ovf,
  output logic              cry
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addend;
  logic              sa, sb, sr;

  always_comb begin
    addend = b + {{(DATA_W-1){1'b0}}, (use_cin & cin)};
    sum    = is_sub ? (a - b) : (a + addend);
    sa     = a[MSB];
    sb     = is_sub ? b[MSB] : addend[MSB];
    sr     = sum[MSB];
    if (is_sub) begin
      ovf = (sa & ~sb & ~sr) | (~sa & sb & sr);
      cry = (~sa & sb) | (sr & (~sa | sb));
    end else begin
      ovf = (sa & sb & ~sr) | (~sa & ~sb & sr);
      cry = (sa & sb) | (~sr & (sa | sb));
    end
  end

  // R6
  always_comb begin
    if (!is_sub && (a[MSB] == addend[MSB]))
      add_sign_chk: assert (ovf == (sum[MSB] != a[MSB]))
        else $error("add overflow disagrees with sign rule");
  end
endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]     a,
  input  logic [DATA_W-1:0]     b,
  input  cc_alu_pkg::logic_e    lop,
  input  logic                  inv_b,
  output logic [DATA_W-1:0]     y
);
  import cc_alu_pkg::*;

  logic [DATA_W-1:0] bb;

  always_comb begin
    bb = inv_b ? ~b : b;
    case (lop)
      LG_OR:   y = a | bb;
      LG_XOR:  y = a ^ bb;
      default: y = a & bb;
    endcase
  end
endmodule

// File: rtl/cc_alu_shift.sv
module cc_alu_shift #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  cc_alu_pkg::shift_e  sop,
  output logic [DATA_W-1:0]   y
);
  import cc_alu_pkg::*;

  localparam int AMT_W = $clog2(DATA_W);
  localparam int MSB   = DATA_W - 1;

  logic [AMT_W-1:0]  amt;
  logic              fill;
  logic [DATA_W-1:0] a_rev;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] stage [AMT_W+1];
  logic [DATA_W-1:0] out_rev;

  assign amt  = b[AMT_W-1:0];
  assign fill = (sop == SH_ARITH) ? a[MSB] : 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign a_rev[gi]   = a[MSB-gi];
      assign out_rev[gi] = stage[AMT_W][MSB-gi];
    end
  endgenerate

  assign src      = (sop == SH_LEFT) ? a_rev : a;
  assign stage[0] = src;

  generate
    for (gi = 0; gi < AMT_W; gi++) begin : g_stage
      localparam int STEP = 1 << gi;
      assign stage[gi+1] = amt[gi]
        ? {{STEP{fill}}, stage[gi][DATA_W-1:STEP]}
        : stage[gi];
    end
  endgenerate

  assign y = (sop == SH_LEFT) ? out_rev : stage[AMT_W];

  // R9
  always_comb begin
    if (sop == SH_ARITH)
      sar_sign_chk: assert (y[MSB] == a[MSB])
        else $error("arithmetic shift lost the sign");
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic [5:0]        op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              flag_we,
  output logic              illegal_op
);
  import cc_alu_pkg::*;

  localparam int MSB = DATA_W - 1;

  dec_t              dec;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] arith_y, logic_y, shift_y;
  logic              arith_v, arith_c;
  logic [DATA_W-1:0] unit_y;

  assign dec = decode_op(op_code);

  cc_alu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) opnd_i (
    .reg_b   (src_b),
    .imm_sel (imm_sel),
    .imm_val (imm_val),
    .opnd_b  (opnd_b)
  );

  cc_alu_addsub #(.DATA_W(DATA_W)) addsub_i (
    .a       (src_a),
    .b       (opnd_b),
    .is_sub  (dec.is_sub),
    .use_cin (dec.use_cin),
    .cin     (carry_in),
    .sum     (arith_y),
    .ovf     (arith_v),
    .cry     (arith_c)
  );

  cc_alu_logic #(.DATA_W(DATA_W)) logic_i (
    .a     (src_a),
    .b     (opnd_b),
    .lop   (dec.lop),
    .inv_b (dec.inv_b),
    .y     (logic_y)
  );

  cc_alu_shift #(.DATA_W(DATA_W)) shift_i (
    .a   (src_a),
    .b   (opnd_b),
    .sop (dec.sop),
    .y   (shift_y)
  );

  always_comb begin
    case (dec.unit)
      UNIT_LOGIC: unit_y = logic_y;
      UNIT_SHIFT: unit_y = shift_y;
      default:    unit_y = arith_y;
    endcase
  end

  always_comb begin
    illegal_op = ~dec.legal;
    result     = dec.legal ? unit_y : '0;
    flag_we    = dec.legal & dec.set_cc;
    flag_n     = 1'b0;
    flag_z     = 1'b0;
    flag_v     = 1'b0;
    flag_c     = 1'b0;
    if (flag_we) begin
      flag_n = result[MSB];
      flag_z = (result == '0);
      if (dec.unit == UNIT_ARITH) begin
        flag_v = arith_v;
        flag_c = arith_c;
      end
    end
  end

  // R11
  always_comb begin
    if (illegal_op)
      illegal_quiet_chk: assert (result == '0 && !flag_we)
        else $error("illegal code left a visible effect");
  end

  // R4
  always_comb begin
    if (!flag_we)
      flags_idle_chk: assert (!flag_n && !flag_z && !flag_v && !flag_c)
        else $error("flags driven without write enable");
  end

  // R8
  always_comb begin
    if (flag_we && dec.unit == UNIT_LOGIC)
      logic_cv_clear_chk: assert (!flag_v && !flag_c)
        else $error("logical flag form set V or C");
  end

  // R5
  always_comb begin
    if (flag_we && result == '0)
      zero_flag_chk: assert (flag_z && !flag_n)
        else $error("zero result without Z");
  end
endmodule

// File: tb/cc_alu_tb_top.sv
module cc_alu_tb_top;

  localparam int NV = 25;
  localparam int VW = 123;

  logic        clk;
  logic        rst_n;
  logic [5:0]  op_code;
  logic [31:0] src_a, src_b;
  logic        imm_sel;
  logic [12:0] imm_val;
  logic        carry_in;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_v, flag_c, flag_we, illegal_op;

  int n_chk;
  int n_bad;
  bit done;

  cc_alu dut_i (
    .op_code    (op_code),
    .src_a      (src_a),
    .src_b      (src_b),
    .imm_sel    (imm_sel),
    .imm_val    (imm_val),
    .carry_in   (carry_in),
    .result     (result),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_v     (flag_v),
    .flag_c     (flag_c),
    .flag_we    (flag_we),
    .illegal_op (illegal_op)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {op, imm_sel, a, b, imm, cin, exp_result, exp_nzvc, exp_we, exp_ill}
  localparam logic [VW-1:0] VEC [NV] = '{
    {6'd0,  1'b0, 32'h00000005, 32'h00000007, 13'h0000, 1'b0, 32'h0000000C, 4'b0000, 1'b0, 1'b0},
    {6'd16, 1'b0, 32'h7FFFFFFF, 32'h00000001, 13'h0000, 1'b0, 32'h80000000, 4'b1010, 1'b1, 1'b0},
    {6'd16, 1'b0, 32'hFFFFFFFF, 32'h00000001, 13'h0000, 1'b0, 32'h00000000, 4'b0101, 1'b1, 1'b0},
    {6'd20, 1'b0, 32'h00000003, 32'h00000005, 13'h0000, 1'b0, 32'hFFFFFFFE, 4'b1001, 1'b1, 1'b0},
    {6'd20, 1'b0, 32'h80000000, 32'h00000001, 13'h0000, 1'b0, 32'h7FFFFFFF, 4'b0010, 1'b1, 1'b0},
    {6'd4,  1'b0, 32'h0000000A, 32'h00000003, 13'h0000, 1'b0, 32'h00000007, 4'b0000, 1'b0, 1'b0},
    {6'd17, 1'b0, 32'hF0F0F0F0, 32'h0F0F0F0F, 13'h0000, 1'b0, 32'h00000000, 4'b0100, 1'b1, 1'b0},
    {6'd5,  1'b0, 32'hFFFF0000, 32'hFF00FF00, 13'h0000, 1'b0, 32'h00FF0000, 4'b0000, 1'b0, 1'b0},
    {6'd22, 1'b0, 32'h00000000, 32'h00000000, 13'h0000, 1'b0, 32'hFFFFFFFF, 4'b1000, 1'b1, 1'b0},
    {6'd7,  1'b0, 32'h12345678, 32'h12345678, 13'h0000, 1'b0, 32'hFFFFFFFF, 4'b0000, 1'b0, 1'b0},
    {6'd19, 1'b0, 32'h80000001, 32'h00000001, 13'h0000, 1'b0, 32'h80000000, 4'b1000, 1'b1, 1'b0},
    {6'd2,  1'b0, 32'h000000F0, 32'h00000F00, 13'h0000, 1'b0, 32'h00000FF0, 4'b0000, 1'b0, 1'b0},
    {6'd8,  1'b0, 32'h00000001, 32'h00000002, 13'h0000, 1'b1, 32'h00000004, 4'b0000, 1'b0, 1'b0},
    {6'd24, 1'b0, 32'hFFFFFFFE, 32'h00000001, 13'h0000, 1'b1, 32'h00000000, 4'b0101, 1'b1, 1'b0},
    {6'd24, 1'b0, 32'hFFFFFFFE, 32'h00000001, 13'h0000, 1'b0, 32'hFFFFFFFF, 4'b1000, 1'b1, 1'b0},
    {6'h25, 1'b0, 32'h00000001, 32'h00000024, 13'h0000, 1'b0, 32'h00000010, 4'b0000, 1'b0, 1'b0},
    {6'h26, 1'b0, 32'h80000000, 32'h0000001F, 13'h0000, 1'b0, 32'h00000001, 4'b0000, 1'b0, 1'b0},
    {6'h27, 1'b0, 32'h80000000, 32'h00000004, 13'h0000, 1'b0, 32'hF8000000, 4'b0000, 1'b0, 1'b0},
    {6'h27, 1'b0, 32'h40000000, 32'h00000021, 13'h0000, 1'b0, 32'h20000000, 4'b0000, 1'b0, 1'b0},
    {6'd0,  1'b1, 32'h0000000A, 32'h0000DEAD, 13'h1FFF, 1'b0, 32'h00000009, 4'b0000, 1'b0, 1'b0},
    {6'd20, 1'b1, 32'h00000000, 32'h00000123, 13'h1000, 1'b0, 32'h00001000, 4'b0001, 1'b1, 1'b0},
    {6'd9,  1'b0, 32'h00000005, 32'h00000005, 13'h0000, 1'b1, 32'h00000000, 4'b0000, 1'b0, 1'b1},
    {6'h3F, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 13'h0000, 1'b1, 32'h00000000, 4'b0000, 1'b0, 1'b1},
    {6'd17, 1'b0, 32'hFFFFFFFF, 32'h80000000, 13'h0000, 1'b1, 32'h80000000, 4'b1000, 1'b1, 1'b0},
    {6'h25, 1'b1, 32'h00000003, 32'hFFFFFFFF, 13'h0003, 1'b0, 32'h00000018, 4'b0000, 1'b0, 1'b0}
  };

  localparam string TAGS [NV] = '{
    "R1",  "R6",  "R6",  "R7",  "R7",  "R1",  "R8",  "R2",  "R2",  "R2",
    "R5",  "R1",  "R3",  "R3",  "R3",  "R9",  "R9",  "R9",  "R9",  "R10",
    "R10", "R11", "R11", "R8",  "R10"
  };

  task automatic apply(input logic [5:0] op, input logic isel, input logic [31:0] a,
                       input logic [31:0] b, input logic [12:0] imm, input logic cin);
    @(negedge clk);
    op_code  = op;
    imm_sel  = isel;
    src_a    = a;
    src_b    = b;
    imm_val  = imm;
    carry_in = cin;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got res=%h nzvc=%b we=%b ill=%b, expected res=%h nzvc=%b we=%b ill=%b",
               tag, act[37:6], act[5:2], act[1], act[0], exp[37:6], exp[5:2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [37:0] observed();
    return {result, flag_n, flag_z, flag_v, flag_c, flag_we, illegal_op};
  endfunction

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    op_code = '0; src_a = '0; src_b = '0; imm_sel = 1'b0; imm_val = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R4: idle inputs (plain add of zeros): zero result, no flag write
    check("R4", observed(), {32'h0, 4'b0000, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(v[122:117], v[116], v[115:84], v[83:52], v[51:39], v[38]);
      check(TAGS[i], observed(), v[37:0]);
    end

    // R4: every plain code 0..8 against its flag form, same result
    for (int k = 0; k <= 8; k++) begin
      logic [31:0] plain_res;
      apply(6'(k), 1'b0, 32'h9ABC0123, 32'h00F0F00F, 13'h0, 1'b1);
      plain_res = result;
      check("R4", {31'h0, flag_n | flag_z | flag_v | flag_c, flag_we, illegal_op}, 38'h0);
      apply(6'(k + 16), 1'b0, 32'h9ABC0123, 32'h00F0F00F, 13'h0, 1'b1);
      check("R4", {result, flag_we, 5'b0}, {plain_res, 1'b1, 5'b0});
    end

    // R10: src_b changes alone must not move the result with imm_sel high
    apply(6'd3, 1'b1, 32'h0000FFFF, 32'h00000000, 13'h0F0F, 1'b0);
    check("R10", observed(), {32'h0000F0F0, 4'b0000, 1'b0, 1'b0});
    apply(6'd3, 1'b1, 32'h0000FFFF, 32'hFFFFFFFF, 13'h0F0F, 1'b0);
    check("R10", observed(), {32'h0000F0F0, 4'b0000, 1'b0, 1'b0});

    // R11: a code in the unused gap between flag forms and shifts
    apply(6'h24, 1'b0, 32'h1, 32'h1, 13'h0, 1'b0);
    check("R11", observed(), {32'h0, 4'b0000, 1'b0, 1'b1});

    // R9: zero shift count leaves operand unchanged
    apply(6'h26, 1'b0, 32'hCAFEF00D, 32'hFFFFFFE0, 13'h0, 1'b0);
    check("R9", observed(), {32'hCAFEF00D, 4'b0000, 1'b0, 1'b0});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule